// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a narrow byte-wide host port reach a 32-bit internal register space. The host first writes a 16-bit target address and, for stores, four data bytes into staging registers at fixed byte offsets. It starts an access by *reading* a command offset. That same read returns the status of that kind of access as it stood just before the launch. The host then polls a status offset until the access finishes. Read results are fetched from four further byte offsets, most significant byte first.

Toward the register space the block drives a request/acknowledge bus. It holds a request, a write flag, an address and write data until it sees an acknowledge, which may carry an error flag. It stops waiting after a fixed number of cycles and reports a failure if no acknowledge arrives. A single access engine serves both directions. Its states are `ENG_IDLE`, `ENG_RD_WAIT` and `ENG_WR_WAIT`, with these transitions:
- `ENG_IDLE` to `ENG_RD_WAIT` on a read-launch.
- `ENG_IDLE` to `ENG_WR_WAIT` on a write-launch.
- Either wait state back to `ENG_IDLE` on an acknowledge or on a timeout.

The block also reports its own serial-slave device address, which is a base value plus a strap input.

Top module: `ireg_bridge`

## Requirements
- R1: `slave_id` equals 0x66 plus `strap_sel` (0x66 or 0x67).
- R2: Host byte writes load staging registers, and each one reads back at its own offset:
  - 0xF0 and 0xF1 hold the high and low bytes of the read address.
  - 0xF2 and 0xF3 hold the high and low bytes of the write address.
  - 0xF8 through 0xFB hold the write data, with 0xF8 as bits 31:24 and 0xFB as bits 7:0.
- R3: A host read of 0xFC returns the read status held before that cycle. When the engine is idle, it starts an access with `bus_req`=1, `bus_we`=0 and `bus_addr` equal to the read address.
- R4: The read status at 0xFD behaves as follows:
  - It is 0xFF after reset.
  - It is 0x01 while a read is pending.
  - It becomes 0x00 after an acknowledge without error.
  - It becomes 0x02 after an acknowledge with error or after a timeout.
- R5: A host read of 0xFE returns the write status held before that cycle. When the engine is idle, it starts an access with `bus_req`=1, `bus_we`=1, `bus_addr` equal to the write address and `bus_wdata` equal to the write data.
- R6: The write status at 0xFF behaves as follows:
  - It is 0xFF after reset.
  - It is 0x05 while a write is pending.
  - It becomes 0x04 on success.
  - It becomes 0x06 on an error acknowledge or a timeout.
- R7: Offsets 0xF4 to 0xF7 return the last successful read data, with 0xF4 as bits 31:24. This data is updated only by an error-free read acknowledge and is kept on failure. Host writes to these offsets are ignored.
- R8: If no acknowledge arrives, `bus_req` stays high for exactly TIMEOUT (256) cycles. It then drops and the access ends with its failure code.
- R9: While a read is pending, writes to 0xF0/0xF1 are ignored. While a write is pending, writes to 0xF2/0xF3 and 0xF8 to 0xFB are ignored. Staging registers of the other kind still accept writes.
- R10: A launch read while the engine is busy starts nothing. It leaves the other kind's status unchanged and still returns that status.
- R11: Host reads of offsets below 0xF0 return 0x00. Host writes to them, and to 0xFC to 0xFF, change no readable state.
- R12: While `bus_req` is high and no acknowledge or timeout has occurred, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay stable into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_sel | input | 1 | Interface select strap added to the device address |
| slave_id | output | 7 | Serial-slave device address |
| hb_wr | input | 1 | Host byte write strobe |
| hb_rd | input | 1 | Host byte read strobe (launches at 0xFC/0xFE) |
| hb_off | input | 8 | Host byte offset |
| hb_wdata | input | 8 | Host write byte |
| hb_rdata | output | 8 | Host read byte, combinational from `hb_off` |
| bus_req | output | 1 | Internal access request |
| bus_we | output | 1 | Internal access is a write |
| bus_addr | output | 16 | Internal register address |
| bus_wdata | output | 32 | Internal write data |
| bus_ack | input | 1 | Access acknowledge |
| bus_err | input | 1 | Error qualifier on acknowledge |
| bus_rdata | input | 32 | Internal read data, valid with acknowledge |

## Verification
The assertions assume the following about the inputs:
- The host never raises `hb_wr` and `hb_rd` in the same cycle.
- `bus_ack` is only asserted while `bus_req` is high, so every acknowledge belongs to the access in progress.

The stimulus respects both assumptions. It drives one host operation per call, changing inputs on the falling edge and releasing the strobe a cycle later. The bus responder raises a one-cycle acknowledge only after a launch, and only while the bench knows a request is open. Timeout cases simply leave `bus_ack` low.

// File: rtl/ireg_pkg.sv
package ireg_pkg;

    // Byte offsets on the host port
    localparam logic [7:0] OFF_RA_HI   = 8'hF0;
    localparam logic [7:0] OFF_RA_LO   = 8'hF1;
    localparam logic [7:0] OFF_WA_HI   = 8'hF2;
    localparam logic [7:0] OFF_WA_LO   = 8'hF3;
    localparam logic [7:0] OFF_RD_BASE = 8'hF4;
    localparam logic [7:0] OFF_WD_BASE = 8'hF8;
    localparam logic [7:0] OFF_GO_RD   = 8'hFC;
    localparam logic [7:0] OFF_RD_STAT = 8'hFD;
    localparam logic [7:0] OFF_GO_WR   = 8'hFE;
    localparam logic [7:0] OFF_WR_STAT = 8'hFF;
    localparam logic [7:0] OFF_MAP_LO  = 8'hF0;

    // Status codes
    localparam logic [7:0] ST_RESET   = 8'hFF;
    localparam logic [7:0] ST_RD_OK   = 8'h00;
    localparam logic [7:0] ST_RD_BUSY = 8'h01;
    localparam logic [7:0] ST_RD_FAIL = 8'h02;
    localparam logic [7:0] ST_WR_OK   = 8'h04;
    localparam logic [7:0] ST_WR_BUSY = 8'h05;
    localparam logic [7:0] ST_WR_FAIL = 8'h06;

    typedef enum logic [1:0] {
        ENG_IDLE    = 2'd0,
        ENG_RD_WAIT = 2'd1,
        ENG_WR_WAIT = 2'd2
    } eng_state_t;

endpackage

// File: rtl/ireg_stage.sv
module ireg_stage
    import ireg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        off,
    input  logic [7:0]        wbyte,
    input  logic              rd_busy,
    input  logic              wr_busy,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int HI_W = ADDR_W - 8;
    localparam int NB   = DATA_W / 8;

    logic [ADDR_W-1:0] rd_addr_q;
    logic [ADDR_W-1:0] wr_addr_q;

    wire rd_open = wr_en && !rd_busy;
    wire wr_open = wr_en && !wr_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr_q <= '0;
        end else if (rd_open) begin
            if (off == OFF_RA_HI) rd_addr_q[ADDR_W-1:8] <= wbyte[HI_W-1:0];
            if (off == OFF_RA_LO) rd_addr_q[7:0]        <= wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr_q <= '0;
        end else if (wr_open) begin
            if (off == OFF_WA_HI) wr_addr_q[ADDR_W-1:8] <= wbyte[HI_W-1:0];
            if (off == OFF_WA_LO) wr_addr_q[7:0]        <= wbyte;
        end
    end

    // One staging byte per data lane; lowest offset holds the top byte
    for (genvar g = 0; g < NB; g++) begin : g_lane
        localparam logic [7:0] LANE_OFF = OFF_WD_BASE + 8'(g);
        logic [7:0] b_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                         b_q <= '0;
            else if (wr_open && off == LANE_OFF) b_q <= wbyte;
        end
        assign wr_data[8*(NB-1-g) +: 8] = b_q;
    end

    assign rd_addr = rd_addr_q;
    assign wr_addr = wr_addr_q;

    // R9: staging of a pending kind is frozen
    a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |=> $stable(rd_addr_q));
    a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |=> ($stable(wr_addr_q) && $stable(wr_data)));

endmodule

// File: rtl/ireg_engine.sv
module ireg_engine
    import ireg_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_rd,
    input  logic              go_wr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              rd_busy,
    output logic              wr_busy,
    output logic [7:0]        rd_stat,
    output logic [7:0]        wr_stat,
    output logic [DATA_W-1:0] rd_data
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);

    eng_state_t        state_q, state_d;
    logic [TW-1:0]     tmr_q;
    logic [7:0]        rd_stat_q, wr_stat_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              timeout_hit;

    assign timeout_hit = (state_q != ENG_IDLE) && (tmr_q == T_LAST) && !bus_ack;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: begin
                if (go_rd)      state_d = ENG_RD_WAIT;
                else if (go_wr) state_d = ENG_WR_WAIT;
            end
            ENG_RD_WAIT: if (bus_ack || timeout_hit) state_d = ENG_IDLE;
            ENG_WR_WAIT: if (bus_ack || timeout_hit) state_d = ENG_IDLE;
            default:     state_d = ENG_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        rd_busy   = (state_q == ENG_RD_WAIT);
        wr_busy   = (state_q == ENG_WR_WAIT);
        bus_req   = rd_busy || wr_busy;
        bus_we    = wr_busy;
        bus_addr  = wr_busy ? wr_addr : rd_addr;
        bus_wdata = wr_busy ? wr_data : '0;
    end

    // Wait timer
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ENG_IDLE) tmr_q <= '0;
        else if (!bus_ack)                 tmr_q <= tmr_q + 1'b1;
    end

    // Status and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_stat_q <= ST_RESET;
            wr_stat_q <= ST_RESET;
            rd_data_q <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (go_rd)      rd_stat_q <= ST_RD_BUSY;
                    else if (go_wr) wr_stat_q <= ST_WR_BUSY;
                end
                ENG_RD_WAIT: begin
                    if (bus_ack) begin
                        rd_stat_q <= bus_err ? ST_RD_FAIL : ST_RD_OK;
                        if (!bus_err) rd_data_q <= bus_rdata;
                    end else if (timeout_hit) begin
                        rd_stat_q <= ST_RD_FAIL;
                    end
                end
                ENG_WR_WAIT: begin
                    if (bus_ack)          wr_stat_q <= bus_err ? ST_WR_FAIL : ST_WR_OK;
                    else if (timeout_hit) wr_stat_q <= ST_WR_FAIL;
                end
                default: ;
            endcase
        end
    end

    assign rd_stat = rd_stat_q;
    assign wr_stat = wr_stat_q;
    assign rd_data = rd_data_q;

    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !timeout_hit) |=>
            (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
    a_r4_rd_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |-> (rd_stat_q == ST_RD_BUSY));
    a_r6_wr_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> (wr_stat_q == ST_WR_BUSY));
    a_r7_keep_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && bus_ack && bus_err) |=> $stable(rd_data_q));
    a_r8_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (int'(tmr_q) < TIMEOUT));
    a_r10_no_cross_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && go_wr) |=> !wr_busy);

endmodule

// File: rtl/ireg_rdmux.sv
module ireg_rdmux
    import ireg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic [7:0]        off,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [7:0]        rd_stat,
    input  logic [7:0]        wr_stat,
    output logic [7:0]        rbyte
);
    localparam int NB = DATA_W / 8;

    always_comb begin
        rbyte = 8'h00;
        if (off >= OFF_MAP_LO) begin
            unique case (off)
                OFF_RA_HI:   rbyte = 8'(rd_addr[ADDR_W-1:8]);
                OFF_RA_LO:   rbyte = rd_addr[7:0];
                OFF_WA_HI:   rbyte = 8'(wr_addr[ADDR_W-1:8]);
                OFF_WA_LO:   rbyte = wr_addr[7:0];
                OFF_GO_RD,
                OFF_RD_STAT: rbyte = rd_stat;
                OFF_GO_WR,
                OFF_WR_STAT: rbyte = wr_stat;
                default: begin
                    for (int i = 0; i < NB; i++) begin
                        if (off == OFF_RD_BASE + 8'(i)) rbyte = rd_data[8*(NB-1-i) +: 8];
                        if (off == OFF_WD_BASE + 8'(i)) rbyte = wr_data[8*(NB-1-i) +: 8];
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
    import ireg_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 32,
    parameter int          TIMEOUT = 256,
    parameter logic [6:0]  ID_BASE = 7'h66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_sel,
    output logic [6:0]        slave_id,
    input  logic              hb_wr,
    input  logic              hb_rd,
    input  logic [7:0]        hb_off,
    input  logic [7:0]        hb_wdata,
    output logic [7:0]        hb_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata
);
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              rd_busy, wr_busy;
    logic [7:0]        rd_stat, wr_stat;
    logic              go_rd, go_wr;

    assign slave_id = ID_BASE + {6'd0, strap_sel};
    assign go_rd    = hb_rd && (hb_off == OFF_GO_RD);
    assign go_wr    = hb_rd && (hb_off == OFF_GO_WR);

    ireg_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(hb_wr), .off(hb_off), .wbyte(hb_wdata),
        .rd_busy(rd_busy), .wr_busy(wr_busy),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    ireg_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_engine (
        .clk(clk), .rst_n(rst_n), .go_rd(go_rd), .go_wr(go_wr),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_busy(rd_busy), .wr_busy(wr_busy), .rd_stat(rd_stat), .wr_stat(wr_stat),
        .rd_data(rd_data)
    );

    ireg_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
        .off(hb_off), .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_stat(rd_stat), .wr_stat(wr_stat), .rbyte(hb_rdata)
    );

    // R3/R5: launch only when idle, request follows one edge later
    a_r3_launch_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (go_rd && !bus_req) |=> (bus_req && !bus_we));
    a_r5_launch_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && !bus_req) |=> (bus_req && bus_we));

endmodule

// File: tb/sim_ireg_bridge.sv
module sim_ireg_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_sel = 1'b0;
    logic [6:0]  slave_id;
    logic        hb_wr = 1'b0, hb_rd = 1'b0;
    logic [7:0]  hb_off = 8'h00, hb_wdata = 8'h00, hb_rdata;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = 32'h0;

    int n_cmp = 0, n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    ireg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .slave_id(slave_id),
        .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_off(hb_off), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] off, input logic [7:0] d);
        @(negedge clk); hb_wr = 1'b1; hb_off = off; hb_wdata = d;
        @(negedge clk); hb_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] off, output logic [7:0] d);
        @(negedge clk); hb_rd = 1'b1; hb_off = off;
        #1 d = hb_rdata;
        @(negedge clk); hb_rd = 1'b0;
    endtask

    // Wait lat cycles, then one-cycle acknowledge; captures bus outputs at that time
    task automatic respond(input int lat, input logic err, input logic [31:0] rd,
                           output logic [15:0] a, output logic we, output logic [31:0] wd);
        repeat (lat) @(negedge clk);
        @(negedge clk); bus_ack = 1'b1; bus_err = err; bus_rdata = rd;
        a = bus_addr; we = bus_we; wd = bus_wdata;
        @(negedge clk); bus_ack = 1'b0; bus_err = 1'b0;
    endtask

    task automatic rd_word(output logic [31:0] w);
        logic [7:0] b;
        w = '0;
        for (int i = 0; i < 4; i++) begin
            host_rd(8'hF4 + 8'(i), b);
            w = {w[23:0], b};
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] a;
        logic        we;
        logic [31:0] wd, w, exp_data;
        logic [7:0]  prev_rs, prev_ws;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        host_rd(8'hFD, b); chk("R4 reset read status", b, 8'hFF);
        host_rd(8'hFF, b); chk("R6 reset write status", b, 8'hFF);
        host_rd(8'hF4, b); chk("R7 reset read data", b, 8'h00);
        host_rd(8'hF0, b); chk("R2 reset staging", b, 8'h00);
        chk("R12 reset no request", bus_req, 1'b0);

        // R1 device address
        #1 chk("R1 id strap0", slave_id, 7'h66);
        strap_sel = 1'b1; #1 chk("R1 id strap1", slave_id, 7'h67);
        strap_sel = 1'b0;

        // Read sweep
        prev_rs = 8'hFF; exp_data = 32'h0;
        for (int k = 0; k < 8; k++) begin
            logic [15:0] ad;
            logic [31:0] dv;
            logic        e;
            ad = 16'h1357 * 16'(k + 1) ^ 16'h00A0;
            dv = 32'hA5000000 + 32'(k) * 32'h01030507;
            e  = (k == 3) || (k == 6);
            host_wr(8'hF0, ad[15:8]);
            host_wr(8'hF1, ad[7:0]);
            host_rd(8'hF0, b); chk("R2 read addr hi readback", b, ad[15:8]);
            host_rd(8'hFC, b); chk("R3 launch returns prior read status", b, prev_rs);
            host_rd(8'hFD, b); chk("R4 read pending", b, 8'h01);
            chk("R3 request high", bus_req, 1'b1);
            respond(k, e, dv, a, we, wd);
            chk("R3 bus addr", a, ad);
            chk("R3 bus read", we, 1'b0);
            host_rd(8'hFD, b); chk("R4 read final", b, e ? 8'h02 : 8'h00);
            if (!e) exp_data = dv;
            rd_word(w); chk("R7 read data MSB first", w, exp_data);
            prev_rs = e ? 8'h02 : 8'h00;
        end

        // Write sweep
        prev_ws = 8'hFF;
        for (int k = 0; k < 8; k++) begin
            logic [15:0] ad;
            logic [31:0] dv;
            logic        e;
            ad = 16'hF00D - 16'(k) * 16'h0111;
            dv = 32'h01020304 * 32'(k + 3);
            e  = (k == 5);
            host_wr(8'hF2, ad[15:8]);
            host_wr(8'hF3, ad[7:0]);
            for (int i = 0; i < 4; i++) host_wr(8'hF8 + 8'(i), dv[8*(3-i) +: 8]);
            host_rd(8'hFA, b); chk("R2 write data lane readback", b, dv[15:8]);
            host_rd(8'hFE, b); chk("R5 launch returns prior write status", b, prev_ws);
            host_rd(8'hFF, b); chk("R6 write pending", b, 8'h05);
            respond(k + 1, e, 32'hDEADBEEF, a, we, wd);
            chk("R5 bus addr", a, ad);
            chk("R5 bus write", we, 1'b1);
            chk("R5 bus wdata", wd, dv);
            host_rd(8'hFF, b); chk("R6 write final", b, e ? 8'h06 : 8'h04);
            rd_word(w); chk("R7 read data untouched by write", w, exp_data);
            prev_ws = e ? 8'h06 : 8'h04;
        end

        // Read timeout
        host_wr(8'hF0, 8'h44); host_wr(8'hF1, 8'h55);
        host_rd(8'hFC, b);
        repeat (255) @(negedge clk);
        chk("R8 request still high at 255", bus_req, 1'b1);
        @(negedge clk);
        chk("R8 request dropped at 256", bus_req, 1'b0);
        host_rd(8'hFD, b); chk("R8 read timeout status", b, 8'h02);
        rd_word(w); chk("R7 data kept after timeout", w, exp_data);

        // Write timeout
        host_rd(8'hFE, b);
        repeat (256) @(negedge clk);
        chk("R8 write request dropped", bus_req, 1'b0);
        host_rd(8'hFF, b); chk("R8 write timeout status", b, 8'h06);

        // Hold and cross-kind behaviour during a pending read
        host_wr(8'hF0, 8'h12); host_wr(8'hF1, 8'h34);
        host_rd(8'hFC, b);
        host_wr(8'hF0, 8'h99);
        host_wr(8'hF2, 8'h7E);
        host_rd(8'hF0, b); chk("R9 read addr frozen while read pending", b, 8'h12);
        host_rd(8'hF2, b); chk("R9 write addr accepted during read", b, 8'h7E);
        host_rd(8'hFE, b); chk("R10 busy launch returns write status", b, 8'h06);
        @(negedge clk);
        chk("R10 no write started", bus_we, 1'b0);
        respond(0, 1'b0, 32'h0BADF00D, a, we, wd);
        chk("R9 pending read uses frozen address", a, 16'h1234);
        chk("R10 engine idle after read", bus_req, 1'b0);
        host_rd(8'hFF, b); chk("R10 write status unchanged", b, 8'h06);
        exp_data = 32'h0BADF00D;

        // Hold during a pending write
        host_wr(8'hF8, 8'h11);
        host_rd(8'hFE, b);
        host_wr(8'hF8, 8'h22);
        host_wr(8'hF3, 8'h33);
        host_wr(8'hF1, 8'h66);
        host_rd(8'hF8, b); chk("R9 write data frozen while write pending", b, 8'h11);
        host_rd(8'hF1, b); chk("R9 read addr accepted during write", b, 8'h66);
        respond(2, 1'b0, 32'h0, a, we, wd);
        chk("R9 pending write uses frozen data", wd[31:24], 8'h11);

        // Undefined and read-only offsets
        host_rd(8'h10, b); chk("R11 undefined read", b, 8'h00);
        host_rd(8'hEF, b); chk("R11 undefined read EF", b, 8'h00);
        host_wr(8'h00, 8'hAA);
        host_wr(8'hF4, 8'h55);
        host_wr(8'hFD, 8'h77);
        host_wr(8'hFF, 8'h77);
        host_rd(8'h00, b); chk("R11 undefined write ignored", b, 8'h00);
        rd_word(w); chk("R7 read data offsets not writable", w, exp_data);
        host_rd(8'hFD, b); chk("R11 status write ignored", b, 8'h00);
        host_rd(8'hFF, b); chk("R11 wr status write ignored", b, 8'h04);
        chk("R11 no launch from write strobe", bus_req, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule